// File: doc/BRIEF.md
# DMA Request Phase Sequencer

This block carries one decoded DMA request through a fixed order of phases. It takes the request when it is idle, checks it for encoding errors, and then runs the phases the request enables, one after another. First it waits for an optional pre-transfer semaphore condition. Next it starts an optional transfer on an external data mover. Then it applies the post-transfer semaphore commands in slot order. Last it issues an optional doorbell write. When the command byte asks for it, the block then hands out a completion record that holds the request identifier and a status code.

The data mover, the semaphore storage and the memory write path are all outside the block. Each of them is driven through a simple valid/done handshake. The block asserts one phase output at a time and holds its payload steady until the matching acknowledge arrives.

Top module: `req_phase_seq`

## Requirements
- R1: `req_ready` is high only while no phase output is active. The descriptor is captured on the cycle in which `req_valid` and `req_ready` are both high, so later changes on the request inputs have no effect on that request.
- R2: The phases run strictly in this order: presync semaphore, transfer, postsync semaphores, doorbell, completion. At most one of `dma_valid`, `sem_valid`, `wr_valid` and `cpl_valid` is high at a time.
- R3: A semaphore word with bit 31 set (enabled) and bit 22 set (pre-transfer) is presented first, with `sem_pre` high. The sequencer waits there until `sem_done` is high.
- R4: Command bits [1:0] set the transfer direction: 0 means no transfer, 1 is toward the device, 2 is away from the device. Command bit 3 is copied to `dma_bulk`. The source, destination and 32-bit length are presented until `dma_done` is high.
- R5: Every enabled word with bit 22 clear is issued after the transfer with `sem_pre` low, one per handshake, in ascending slot order. Words with bit 31 clear are never issued.
- R6: Doorbell attribute bit 7 enables the write. Attribute bits [1:0] select the width: 0 is 32 bits, 1 is 16 bits, 2 is 8 bits. `wr_size` carries that code and `wr_data` keeps only the low bits of the selected width.
- R7: When command bit 4 is set, a record is presented with `cpl_id` equal to the request identifier, `cpl_code` equal to 0 on success, and `cpl_force` equal to command bit 7. It is held until `cpl_ready` is high.
- R8: Four encoding errors are checked, listed here in decreasing priority. Each one suppresses every phase and leaves only the record, with a non-zero code:
  - transfer type 3 gives code 1;
  - an enabled doorbell of width code 3 gives code 2;
  - an enabled doorbell whose address is not aligned to its width gives code 3;
  - more than one enabled presync word gives code 4.
- R9: When command bit 4 is clear, no record is emitted, even on error, and the block returns to idle.
- R10: Command bits 2, 5 and 6 and attribute bits [6:2] have no effect on any output. A disabled doorbell with width code 3 is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Sequencer idle, descriptor accepted |
| req_id | input | ID_W | Request identifier |
| req_cmd | input | 8 | Command byte |
| req_src | input | ADDR_W | Transfer source or list address |
| req_dst | input | ADDR_W | Transfer destination |
| req_len | input | LEN_W | Transfer length |
| req_db_addr | input | ADDR_W | Doorbell address |
| req_db_attr | input | 8 | Doorbell attributes |
| req_db_data | input | DB_W | Doorbell data |
| req_sem | input | NUM_SEM*SEM_W | Semaphore words, slot 0 in the low bits |
| dma_valid | output | 1 | Transfer request |
| dma_dir | output | 2 | Transfer direction code |
| dma_bulk | output | 1 | Bulk (1) or list (0) transfer |
| dma_src | output | ADDR_W | Source address |
| dma_dst | output | ADDR_W | Destination address |
| dma_len | output | LEN_W | Length |
| dma_done | input | 1 | Transfer finished |
| sem_valid | output | 1 | Semaphore command request |
| sem_pre | output | 1 | Command is the pre-transfer condition |
| sem_word | output | SEM_W | Semaphore command word |
| sem_done | input | 1 | Condition met and command applied |
| wr_valid | output | 1 | Doorbell write request |
| wr_addr | output | ADDR_W | Doorbell address |
| wr_data | output | DB_W | Masked doorbell data |
| wr_size | output | 2 | Width code |
| wr_ready | input | 1 | Doorbell write accepted |
| cpl_valid | output | 1 | Completion record valid |
| cpl_id | output | ID_W | Request identifier |
| cpl_code | output | CODE_W | Status code, 0 on success |
| cpl_force | output | 1 | Force-interrupt flag |
| cpl_ready | input | 1 | Record taken |

## Verification
The hold assertions assume the external units acknowledge only while the matching valid is high. They also assume an acknowledge is never sent before the request it answers has appeared. The bench's responders meet both conditions: each samples the one active valid at the falling edge, waits 0 to 2 cycles, and then raises its acknowledge for exactly one edge. Request fields are treated as meaningful only on the handshake edge. The bench scrambles them right after that edge to show they were captured.

// File: rtl/req_phase_pkg.sv
package req_phase_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PRE  = 3'd1,
      PH_XFER = 3'd2,
      PH_POST = 3'd3,
      PH_BELL = 3'd4,
      PH_CPL  = 3'd5
   } phase_e;

   localparam int unsigned CMD_FORCE = 7;
   localparam int unsigned CMD_CPL   = 4;
   localparam int unsigned CMD_BULK  = 3;
   localparam int unsigned ATTR_EN   = 7;
   localparam int unsigned SEM_EN    = 31;
   localparam int unsigned SEM_PRE   = 22;

   localparam logic [1:0] XT_ILLEGAL = 2'd3;
   localparam logic [1:0] WD_32      = 2'd0;
   localparam logic [1:0] WD_16      = 2'd1;
   localparam logic [1:0] WD_8       = 2'd2;
   localparam logic [1:0] WD_RSVD    = 2'd3;

   localparam logic [2:0] ERR_NONE     = 3'd0;
   localparam logic [2:0] ERR_XFER     = 3'd1;
   localparam logic [2:0] ERR_WIDTH    = 3'd2;
   localparam logic [2:0] ERR_ALIGN    = 3'd3;
   localparam logic [2:0] ERR_MULTIPRE = 3'd4;

   // next enabled phase strictly after 'cur' in the fixed order
   function automatic phase_e step_after(input phase_e cur, input logic pre,
                                         input logic xfer, input logic post,
                                         input logic bell, input logic cpl);
      phase_e n;
      if (cur < PH_PRE && pre)        n = PH_PRE;
      else if (cur < PH_XFER && xfer) n = PH_XFER;
      else if (cur < PH_POST && post) n = PH_POST;
      else if (cur < PH_BELL && bell) n = PH_BELL;
      else if (cur < PH_CPL && cpl)   n = PH_CPL;
      else                            n = PH_IDLE;
      return n;
   endfunction

endpackage

// File: rtl/req_phase_pick.sv
module req_phase_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]                          mask,
   output logic [((N > 1) ? $clog2(N) : 1)-1:0]  idx,
   output logic [N-1:0]                          onehot,
   output logic                                  any
);
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

   if (N < 1) begin : g_bad_n
      $error("req_phase_pick: N must be at least 1");
   end

   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) begin
            idx    = IW'(i);
            onehot = N'(1) << i;
         end
      end
   end

   assign any = |mask;
endmodule

// File: rtl/req_phase_sem_sel.sv
module req_phase_sem_sel
   import req_phase_pkg::*;
#(
   parameter int unsigned NUM_SEM = 4,
   parameter int unsigned SEM_W   = 32
) (
   input  logic [NUM_SEM*SEM_W-1:0]      words,
   output logic [NUM_SEM-1:0]            pre_mask,
   output logic [NUM_SEM-1:0]            post_mask,
   output logic [$clog2(NUM_SEM+1)-1:0]  pre_count,
   output logic [SEM_W-1:0]              pre_word
);
   localparam int unsigned CNT_W = $clog2(NUM_SEM + 1);

   if (SEM_W <= SEM_EN) begin : g_bad_w
      $error("req_phase_sem_sel: SEM_W too narrow for the enable bit");
   end

   for (genvar s = 0; s < NUM_SEM; s++) begin : g_slot
      logic [SEM_W-1:0] w;
      assign w            = words[s*SEM_W +: SEM_W];
      assign pre_mask[s]  = w[SEM_EN] &  w[SEM_PRE];
      assign post_mask[s] = w[SEM_EN] & ~w[SEM_PRE];
   end

   always_comb begin
      pre_count = '0;
      pre_word  = '0;
      for (int s = 0; s < NUM_SEM; s++) begin
         pre_count = pre_count + CNT_W'(pre_mask[s]);
         if (pre_mask[s]) pre_word = pre_word | words[s*SEM_W +: SEM_W];
      end
   end
endmodule

// File: rtl/req_phase_check.sv
module req_phase_check
   import req_phase_pkg::*;
#(
   parameter int unsigned CNT_W  = 3,
   parameter int unsigned CODE_W = 16
) (
   input  logic [7:0]        cmd,
   input  logic [7:0]        attr,
   input  logic [1:0]        addr_lo,
   input  logic [CNT_W-1:0]  pre_count,
   output logic [CODE_W-1:0] code
);
   if (CODE_W < 3) begin : g_bad_code
      $error("req_phase_check: CODE_W must hold code 4");
   end

   logic misalign;
   logic [2:0] sel;

   always_comb begin
      case (attr[1:0])
         WD_32:   misalign = addr_lo != 2'b00;
         WD_16:   misalign = addr_lo[0];
         default: misalign = 1'b0;
      endcase
   end

   always_comb begin
      if (cmd[1:0] == XT_ILLEGAL)                         sel = ERR_XFER;
      else if (attr[ATTR_EN] && attr[1:0] == WD_RSVD)     sel = ERR_WIDTH;
      else if (attr[ATTR_EN] && misalign)                 sel = ERR_ALIGN;
      else if (pre_count > CNT_W'(1))                     sel = ERR_MULTIPRE;
      else                                                sel = ERR_NONE;
   end

   assign code = CODE_W'(sel);
endmodule

// File: rtl/req_phase_bell.sv
module req_phase_bell
   import req_phase_pkg::*;
#(
   parameter int unsigned DB_W = 32
) (
   input  logic [7:0]      attr,
   input  logic [DB_W-1:0] data_in,
   output logic [DB_W-1:0] data_out,
   output logic [1:0]      size
);
   if (DB_W != 32) begin : g_bad_db
      $error("req_phase_bell: doorbell data must be 32 bits");
   end

   assign size = attr[1:0];

   always_comb begin
      case (attr[1:0])
         WD_16:   data_out = data_in & DB_W'(32'h0000_FFFF);
         WD_8:    data_out = data_in & DB_W'(32'h0000_00FF);
         default: data_out = data_in;
      endcase
   end
endmodule

// File: rtl/req_phase_seq.sv
module req_phase_seq
   import req_phase_pkg::*;
#(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned ID_W    = 16,
   parameter int unsigned CODE_W  = 16,
   parameter int unsigned NUM_SEM = 4,
   parameter int unsigned SEM_W   = 32,
   parameter int unsigned DB_W    = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ID_W-1:0]           req_id,
   input  logic [7:0]                req_cmd,
   input  logic [ADDR_W-1:0]         req_src,
   input  logic [ADDR_W-1:0]         req_dst,
   input  logic [LEN_W-1:0]          req_len,
   input  logic [ADDR_W-1:0]         req_db_addr,
   input  logic [7:0]                req_db_attr,
   input  logic [DB_W-1:0]           req_db_data,
   input  logic [NUM_SEM*SEM_W-1:0]  req_sem,
   output logic                      dma_valid,
   output logic [1:0]                dma_dir,
   output logic                      dma_bulk,
   output logic [ADDR_W-1:0]         dma_src,
   output logic [ADDR_W-1:0]         dma_dst,
   output logic [LEN_W-1:0]          dma_len,
   input  logic                      dma_done,
   output logic                      sem_valid,
   output logic                      sem_pre,
   output logic [SEM_W-1:0]          sem_word,
   input  logic                      sem_done,
   output logic                      wr_valid,
   output logic [ADDR_W-1:0]         wr_addr,
   output logic [DB_W-1:0]           wr_data,
   output logic [1:0]                wr_size,
   input  logic                      wr_ready,
   output logic                      cpl_valid,
   output logic [ID_W-1:0]           cpl_id,
   output logic [CODE_W-1:0]         cpl_code,
   output logic                      cpl_force,
   input  logic                      cpl_ready
);
   localparam int unsigned IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;
   localparam int unsigned CNT_W = $clog2(NUM_SEM + 1);

   if (ADDR_W < 2)  begin : g_bad_addr  $error("req_phase_seq: ADDR_W below 2"); end
   if (LEN_W < 1)   begin : g_bad_len   $error("req_phase_seq: LEN_W below 1"); end
   if (ID_W < 1)    begin : g_bad_id    $error("req_phase_seq: ID_W below 1"); end
   if (NUM_SEM < 1) begin : g_bad_sem   $error("req_phase_seq: NUM_SEM below 1"); end

   // ---------------- capture-side decode ----------------
   logic [NUM_SEM-1:0] in_pre_mask, in_post_mask;
   logic [CNT_W-1:0]   in_pre_cnt;
   logic [SEM_W-1:0]   in_pre_word;
   logic [CODE_W-1:0]  in_code;

   req_phase_sem_sel #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W)) i_sel (
      .words     (req_sem),
      .pre_mask  (in_pre_mask),
      .post_mask (in_post_mask),
      .pre_count (in_pre_cnt),
      .pre_word  (in_pre_word)
   );

   req_phase_check #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_check (
      .cmd       (req_cmd),
      .attr      (req_db_attr),
      .addr_lo   (req_db_addr[1:0]),
      .pre_count (in_pre_cnt),
      .code      (in_code)
   );

   // ---------------- held request ----------------
   phase_e                    st;
   logic [ID_W-1:0]           id_q;
   logic [7:0]                cmd_q;
   logic [ADDR_W-1:0]         src_q, dst_q, dba_q;
   logic [LEN_W-1:0]          len_q;
   logic [7:0]                attr_q;
   logic [DB_W-1:0]           dbd_q;
   logic [NUM_SEM*SEM_W-1:0]  sem_q;
   logic [SEM_W-1:0]          pre_word_q;
   logic                      pre_q;
   logic [NUM_SEM-1:0]        post_q;
   logic [CODE_W-1:0]         code_q;

   logic [IDX_W-1:0]   pick_idx;
   logic [NUM_SEM-1:0] pick_oh;
   logic               post_any;

   req_phase_pick #(.N(NUM_SEM)) i_pick (
      .mask   (post_q),
      .idx    (pick_idx),
      .onehot (pick_oh),
      .any    (post_any)
   );

   logic [DB_W-1:0] bell_data;
   logic [1:0]      bell_size;

   req_phase_bell #(.DB_W(DB_W)) i_bell (
      .attr     (attr_q),
      .data_in  (dbd_q),
      .data_out (bell_data),
      .size     (bell_size)
   );

   logic take, q_xfer, q_bell, q_cpl;
   assign take   = req_valid && req_ready;
   assign q_xfer = cmd_q[1:0] != 2'd0;
   assign q_bell = attr_q[ATTR_EN];
   assign q_cpl  = cmd_q[CMD_CPL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PH_IDLE;
         id_q       <= '0;
         cmd_q      <= '0;
         src_q      <= '0;
         dst_q      <= '0;
         len_q      <= '0;
         dba_q      <= '0;
         attr_q     <= '0;
         dbd_q      <= '0;
         sem_q      <= '0;
         pre_word_q <= '0;
         pre_q      <= 1'b0;
         post_q     <= '0;
         code_q     <= '0;
      end else begin
         unique case (st)
            PH_IDLE: if (take) begin
               id_q       <= req_id;
               cmd_q      <= req_cmd;
               src_q      <= req_src;
               dst_q      <= req_dst;
               len_q      <= req_len;
               dba_q      <= req_db_addr;
               attr_q     <= req_db_attr;
               dbd_q      <= req_db_data;
               sem_q      <= req_sem;
               pre_word_q <= in_pre_word;
               pre_q      <= in_pre_cnt != '0;
               post_q     <= in_post_mask;
               code_q     <= in_code;
               if (in_code != '0)
                  st <= step_after(PH_BELL, 1'b0, 1'b0, 1'b0, 1'b0, req_cmd[CMD_CPL]);
               else
                  st <= step_after(PH_IDLE, in_pre_cnt != '0, req_cmd[1:0] != 2'd0,
                                   |in_post_mask, req_db_attr[ATTR_EN], req_cmd[CMD_CPL]);
            end
            PH_PRE: if (sem_done)
               st <= step_after(PH_PRE, pre_q, q_xfer, post_any, q_bell, q_cpl);
            PH_XFER: if (dma_done)
               st <= step_after(PH_XFER, pre_q, q_xfer, post_any, q_bell, q_cpl);
            PH_POST: if (sem_done) begin
               post_q <= post_q & ~pick_oh;
               if ((post_q & ~pick_oh) == '0)
                  st <= step_after(PH_POST, pre_q, q_xfer, 1'b0, q_bell, q_cpl);
            end
            PH_BELL: if (wr_ready)
               st <= step_after(PH_BELL, pre_q, q_xfer, 1'b0, q_bell, q_cpl);
            PH_CPL: if (cpl_ready)
               st <= PH_IDLE;
            default: st <= PH_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign req_ready = st == PH_IDLE;

   assign dma_valid = st == PH_XFER;
   assign dma_dir   = cmd_q[1:0];
   assign dma_bulk  = cmd_q[CMD_BULK];
   assign dma_src   = src_q;
   assign dma_dst   = dst_q;
   assign dma_len   = len_q;

   assign sem_valid = (st == PH_PRE) || (st == PH_POST);
   assign sem_pre   = st == PH_PRE;
   assign sem_word  = (st == PH_PRE) ? pre_word_q : sem_q[pick_idx*SEM_W +: SEM_W];

   assign wr_valid  = st == PH_BELL;
   assign wr_addr   = dba_q;
   assign wr_data   = bell_data;
   assign wr_size   = bell_size;

   assign cpl_valid = st == PH_CPL;
   assign cpl_id    = id_q;
   assign cpl_code  = code_q;
   assign cpl_force = cmd_q[CMD_FORCE];

   // ---------------- assertions ----------------
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(dma_valid || sem_valid || wr_valid || cpl_valid));

   assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dma_valid, sem_valid, wr_valid, cpl_valid}));

   assert_xfer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_valid && !dma_done |=> dma_valid && $stable(dma_src) && $stable(dma_dst)
                                 && $stable(dma_len) && $stable(dma_dir));

   assert_post_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sem_valid |-> sem_word[SEM_EN] && (sem_word[SEM_PRE] == sem_pre));

   assert_bell_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_size != WD_RSVD)
                   && !(wr_size == WD_32 && wr_addr[1:0] != 2'b00)
                   && !(wr_size == WD_16 && wr_addr[0]));

   assert_bell_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_size == WD_8 |-> wr_data[DB_W-1:8] == '0);

   assert_cpl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_code) && $stable(cpl_id));

endmodule

// File: tb/test_req_phase_seq.sv
`timescale 1ns/1ps
module test_req_phase_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [15:0]  req_id = '0;
   logic [7:0]   req_cmd = '0;
   logic [63:0]  req_src = '0, req_dst = '0, req_db_addr = '0;
   logic [31:0]  req_len = '0, req_db_data = '0;
   logic [7:0]   req_db_attr = '0;
   logic [127:0] req_sem = '0;

   logic dma_valid, dma_bulk, sem_valid, sem_pre, wr_valid, cpl_valid, cpl_force;
   logic [1:0]  dma_dir, wr_size;
   logic [63:0] dma_src, dma_dst, wr_addr;
   logic [31:0] dma_len, sem_word, wr_data;
   logic [15:0] cpl_id, cpl_code;
   logic dma_done = 1'b0, sem_done = 1'b0, wr_ready = 1'b0, cpl_ready = 1'b0;

   req_phase_seq i_req_phase_seq (
      .clk, .rst_n, .req_valid, .req_ready, .req_id, .req_cmd, .req_src, .req_dst,
      .req_len, .req_db_addr, .req_db_attr, .req_db_data, .req_sem,
      .dma_valid, .dma_dir, .dma_bulk, .dma_src, .dma_dst, .dma_len, .dma_done,
      .sem_valid, .sem_pre, .sem_word, .sem_done,
      .wr_valid, .wr_addr, .wr_data, .wr_size, .wr_ready,
      .cpl_valid, .cpl_id, .cpl_code, .cpl_force, .cpl_ready
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model: expected event queue ----------------
   int          q_kind[$];
   logic [63:0] q_a[$], q_b[$], q_c[$];
   string       q_tag[$];

   task automatic push(input int k, input logic [63:0] a, b, c, input string t);
      q_kind.push_back(k); q_a.push_back(a); q_b.push_back(b); q_c.push_back(c); q_tag.push_back(t);
   endtask

   task automatic build_expect(input string tag);
      int npre = 0;
      int code = 0;
      logic [31:0] w;
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         w = req_sem[i*32 +: 32];
         if (w[31] && w[22]) npre++;
      end
      if (req_cmd[1:0] == 2'd3) code = 1;
      else if (req_db_attr[7] && req_db_attr[1:0] == 2'd3) code = 2;
      else if (req_db_attr[7] && ((req_db_attr[1:0] == 2'd0 && req_db_addr[1:0] != 2'd0) ||
                                  (req_db_attr[1:0] == 2'd1 && req_db_addr[0]))) code = 3;
      else if (npre > 1) code = 4;
      if (code == 0) begin
         for (int i = 0; i < 4; i++) begin
            w = req_sem[i*32 +: 32];
            if (w[31] && w[22]) push(2, {32'h0, w}, 64'h0, 64'h1, {tag, " R3 presync"});
         end
         if (req_cmd[1:0] != 2'd0)
            push(1, req_src, req_dst, {29'h0, req_cmd[1:0], req_cmd[3], req_len}, {tag, " R4 transfer"});
         for (int i = 0; i < 4; i++) begin
            w = req_sem[i*32 +: 32];
            if (w[31] && !w[22]) push(2, {32'h0, w}, 64'h0, 64'h0, {tag, " R5 postsync"});
         end
         if (req_db_attr[7]) begin
            d = req_db_data;
            if (req_db_attr[1:0] == 2'd1) d = d & 32'hFFFF;
            if (req_db_attr[1:0] == 2'd2) d = d & 32'hFF;
            push(3, req_db_addr, {32'h0, d}, {62'h0, req_db_attr[1:0]}, {tag, " R6 doorbell"});
         end
      end
      if (req_cmd[4])
         push(4, {48'h0, req_id}, code, {63'h0, req_cmd[7]}, {tag, (code != 0) ? " R8 error record" : " R7 record"});
   endtask

   // ---------------- monitor and responders ----------------
   bit fresh = 1;
   bit acked = 0;
   int wait_cnt = 0;
   int lat = 0;
   int ev_no = 0;

   always @(negedge clk) begin
      int nv;
      int k;
      logic [63:0] a, b, c;
      if (rst_n) begin
         if (acked) begin
            dma_done = 0; sem_done = 0; wr_ready = 0; cpl_ready = 0;
            acked = 0; fresh = 1;
         end
         nv = int'(dma_valid) + int'(sem_valid) + int'(wr_valid) + int'(cpl_valid);
         if (nv != 0) begin
            if (dma_valid)      begin k = 1; a = dma_src; b = dma_dst; c = {29'h0, dma_dir, dma_bulk, dma_len}; end
            else if (sem_valid) begin k = 2; a = {32'h0, sem_word}; b = 64'h0; c = {63'h0, sem_pre}; end
            else if (wr_valid)  begin k = 3; a = wr_addr; b = {32'h0, wr_data}; c = {62'h0, wr_size}; end
            else                begin k = 4; a = {48'h0, cpl_id}; b = {48'h0, cpl_code}; c = {63'h0, cpl_force}; end
            if (fresh) begin
               check(nv == 1, "R2 single active phase", nv, 1);
               if (q_kind.size() == 0) begin
                  check(0, "R2/R9 unexpected phase output", k, 0);
               end else begin
                  check(k == q_kind[0], {q_tag[0], " (R2 phase order)"}, k, q_kind[0]);
                  check(a == q_a[0], {q_tag[0], " field a"}, a, q_a[0]);
                  check(b == q_b[0], {q_tag[0], " field b"}, b, q_b[0]);
                  check(c == q_c[0], {q_tag[0], " field c"}, c, q_c[0]);
                  void'(q_kind.pop_front()); void'(q_a.pop_front()); void'(q_b.pop_front());
                  void'(q_c.pop_front()); void'(q_tag.pop_front());
               end
               fresh = 0; wait_cnt = 0; lat = ev_no % 3; ev_no++;
            end
            if (wait_cnt >= lat) begin
               case (k)
                  1: dma_done = 1;
                  2: sem_done = 1;
                  3: wr_ready = 1;
                  default: cpl_ready = 1;
               endcase
               acked = 1;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   // ---------------- request driver ----------------
   task automatic run_req(input string tag);
      bit idle;
      build_expect(tag);
      @(negedge clk);
      check(req_ready, {tag, " R1 ready when idle"}, req_ready, 1);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      // R1: fields after the handshake must not matter
      req_src = ~req_src; req_dst = ~req_dst; req_len = ~req_len; req_id = ~req_id;
      req_cmd = ~req_cmd; req_db_addr = ~req_db_addr; req_db_attr = ~req_db_attr;
      req_db_data = ~req_db_data; req_sem = ~req_sem;
      idle = 0;
      for (int i = 0; i < 200; i++) begin
         if (q_kind.size() == 0 && req_ready && !dma_valid && !sem_valid && !wr_valid && !cpl_valid) begin
            idle = 1;
            break;
         end
         @(negedge clk);
      end
      check(idle, {tag, " R1/R9 all phases done, back to idle"}, q_kind.size(), 0);
      q_kind.delete(); q_a.delete(); q_b.delete(); q_c.delete(); q_tag.delete();
   endtask

   function automatic logic [31:0] sw(input bit en, input bit pre, input logic [2:0] op,
                                      input logic [4:0] idx, input logic [11:0] val);
      return {en, 2'b00, 2'b00, op, 1'b0, pre, 1'b0, idx, 4'h0, val};
   endfunction

   task automatic clear_req();
      req_id = '0; req_cmd = '0; req_src = '0; req_dst = '0; req_len = '0;
      req_db_addr = '0; req_db_attr = '0; req_db_data = '0; req_sem = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(req_ready == 1, "R1 reset: ready", req_ready, 1);
      check({dma_valid, sem_valid, wr_valid, cpl_valid} == 4'b0, "R2 reset: no phase active",
            {dma_valid, sem_valid, wr_valid, cpl_valid}, 0);

      // plain bulk transfer toward device with record
      clear_req(); req_id = 16'h0011; req_cmd = 8'h19; req_src = 64'h1000; req_dst = 64'h2000;
      req_len = 32'hFFFF_FFF0;
      run_req("T1");

      // all phases, list transfer away from device, force flag, reserved cmd bits set (R10)
      clear_req(); req_id = 16'h0A22; req_cmd = 8'hF6; req_src = 64'hAAAA_0000_1111_0000;
      req_dst = 64'h5555; req_len = 32'd64; req_db_addr = 64'h8000_0004; req_db_attr = 8'h80;
      req_db_data = 32'hCAFE_F00D;
      req_sem = {sw(1,0,3'd3,5'd9,12'h001), sw(0,1,3'd4,5'd2,12'h002),
                 sw(1,1,3'd6,5'd1,12'h003), sw(1,0,3'd2,5'd0,12'h004)};
      run_req("T2");

      // 16-bit doorbell, no transfer, attribute reserved bits set (R10)
      clear_req(); req_id = 16'h0033; req_cmd = 8'h10; req_db_addr = 64'h42; req_db_attr = 8'hFD;
      req_db_data = 32'hDEAD_BEEF;
      run_req("T3");

      // 8-bit doorbell at odd address, postsync only
      clear_req(); req_id = 16'h0044; req_cmd = 8'h12; req_len = 32'd8; req_db_addr = 64'h43;
      req_db_attr = 8'h82; req_db_data = 32'h1234_56EF;
      req_sem = {96'h0, sw(1,0,3'd1,5'd7,12'hABC)};
      run_req("T4");

      // R8 code 1: illegal transfer type, presync present but skipped
      clear_req(); req_id = 16'h0055; req_cmd = 8'h13; req_sem = {96'h0, sw(1,1,3'd5,5'd3,12'h010)};
      run_req("T5");

      // R8 code 2: enabled reserved width
      clear_req(); req_id = 16'h0066; req_cmd = 8'h11; req_db_attr = 8'h83;
      run_req("T6");

      // R10: reserved width with doorbell disabled is fine
      clear_req(); req_id = 16'h0077; req_cmd = 8'h10; req_db_attr = 8'h03;
      run_req("T7");

      // R8 code 3: misaligned 32-bit and 16-bit doorbells
      clear_req(); req_id = 16'h0088; req_cmd = 8'h11; req_db_attr = 8'h80; req_db_addr = 64'h102;
      run_req("T8");
      clear_req(); req_id = 16'h0099; req_cmd = 8'h10; req_db_attr = 8'h81; req_db_addr = 64'h101;
      run_req("T9");

      // R8 code 4: two presync words
      clear_req(); req_id = 16'h00AA; req_cmd = 8'h91;
      req_sem = {sw(1,1,3'd4,5'd1,12'h1), 64'h0, sw(1,1,3'd5,5'd2,12'h2)};
      run_req("T10");

      // R8 priority: illegal type and misaligned bell and two presync -> code 1
      clear_req(); req_id = 16'h00BB; req_cmd = 8'h13; req_db_attr = 8'h80; req_db_addr = 64'h3;
      req_sem = {sw(1,1,3'd4,5'd1,12'h1), sw(1,1,3'd4,5'd1,12'h1), 64'h0};
      run_req("T11");

      // R9: error with record disabled emits nothing
      clear_req(); req_id = 16'h00CC; req_cmd = 8'h03;
      run_req("T12");

      // R9: valid request without record, transfer and doorbell only
      clear_req(); req_id = 16'h00DD; req_cmd = 8'h0A; req_src = 64'h77; req_dst = 64'h88;
      req_len = 32'd1; req_db_attr = 8'h80; req_db_addr = 64'h10; req_db_data = 32'h1;
      run_req("T13");

      // R5: disabled words ignored, post slots 1 and 3 issued in order
      clear_req(); req_id = 16'h00EE; req_cmd = 8'h11;
      req_sem = {sw(1,0,3'd2,5'd4,12'h4), sw(0,0,3'd3,5'd3,12'h3),
                 sw(1,0,3'd3,5'd2,12'h2), sw(0,1,3'd4,5'd1,12'h1)};
      run_req("T14");

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule